// File: doc/BRIEF.md
# Vector Test-Result Packer

This block collects a stream of per-element test results and turns them into write requests for an integer register file. Each result is either one bit wide (narrow) or four bits wide (wide). A start pulse captures the vector length and the packing options. The block then accepts one result per handshake, for element indices 0 to VL-1. It packs the results from the least significant end of consecutive destination elements. Each completed element is emitted as an offset, a value and a per-bit write enable.

The density of the packing comes from a 2-bit count selector on the source side. Selector codes 00, 01, 10 and 11 ask for 1, 2, 4 and 8 results per destination element. For wide results, a 2-bit destination-width code limits that count to what fits in the element. When the requested count does not fit, the results overflow into the following elements. A scalar mode gathers every result into register offset 0. In that mode the write enable covers only the bits that received results, so the rest of the register is preserved.

Top module: `vec_result_packer`

## Requirements
- R1: In vector narrow mode, selector code c packs k = 1, 2, 4 or 8 results (codes 00, 01, 10, 11) per element. Result i goes to offset i/k at bit (i mod k). Only bit 0 of the result input is used.
- R2: In vector narrow mode, every written value is zero above its packed results, and the write mask covers all XLEN bits.
- R3: In vector wide mode, the width code gives the element width W: 00 = XLEN (64), 01 = 8, 10 = 16, 11 = 32. The capacity is min(2^c, W/4). Result i goes to offset i/capacity, in the nibble at bit 4*(i mod capacity).
- R4: In vector wide mode, every bit of a written element that holds no result is zero. The write mask is exactly the low W bits.
- R5: With a 16-bit destination and selector code 11, eight wide results split into two writes, at offsets 0 and 1, of four nibbles each.
- R6: In scalar narrow mode there is one write, at offset 0. Bit i holds result i, and the write mask covers only bits 0 to VL-1.
- R7: In scalar wide mode there is one write, at offset 0. Nibble i holds result i, and the write mask covers the low 4*VL bits (all bits once 4*VL reaches XLEN). VL above XLEN/4 raises `vl_err_o` until the next start; nibbles past the register are dropped.
- R8: A destination element is written once it reaches capacity or holds the last result, whichever comes first. The write is valid in the cycle after the handshake that completed the element.
- R9: `done_o` is a one-cycle pulse in the cycle after the final write. `res_ready_o` is low from the cycle of that write onward.
- R10: Start is taken only when idle. VL (1 to 64), the mode and the selectors are captured then. Changing those inputs, or pulsing start, during a run has no effect on that run. `res_ready_o` is high for the whole run.
- R11: After reset, `wr_en_o`, `done_o`, `res_ready_o` and `vl_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a run (taken only when idle) |
| vl_i | input | 7 | Number of results, 1 to 64 |
| wide_i | input | 1 | 1: four-bit results, 0: one-bit results |
| scalar_i | input | 1 | 1: pack everything into one register |
| pack_sel_i | input | 2 | Requested results per element: 1, 2, 4, 8 |
| dst_ew_i | input | 2 | Destination width: 00=64, 01=8, 10=16, 11=32 |
| res_valid_i | input | 1 | A result is offered |
| res_data_i | input | 4 | Result value (bit 0 only when narrow) |
| res_ready_o | output | 1 | Block accepts results (high while running) |
| wr_en_o | output | 1 | Register write request, one cycle |
| wr_off_o | output | 6 | Register offset of the write |
| wr_data_o | output | 64 | Element value to write |
| wr_mask_o | output | 64 | Per-bit write enable |
| done_o | output | 1 | Run complete pulse |
| vl_err_o | output | 1 | Scalar wide run with VL above 16 |

## Verification
The assertions assume that a start taken while idle carries a VL between 1 and 64. The bench drives only such lengths, including both ends of the scalar range. They also assume that the configuration inputs are sampled only at that start. The bench deliberately changes them, and pulses start again, in the middle of one run. Result handshakes are offered only at the falling edge. Some runs insert idle cycles between results, so acceptance is tested with and without back-to-back traffic.

// File: rtl/vpack_pkg.sv
// Package: shared constants, width codes and helpers for the result packer.
// Assumes a register width that is a multiple of four bits.
package vpack_pkg;

    localparam int unsigned VP_XLEN   = 64;
    localparam int unsigned VP_VL_MAX = 64;
    localparam int unsigned VP_NIB    = 4;

    // Destination element width codes
    typedef enum logic [1:0] {
        DW_NATIVE = 2'b00,
        DW_BYTE   = 2'b01,
        DW_HALF   = 2'b10,
        DW_WORD   = 2'b11
    } dst_width_e;

    // Width in bits of one destination element for a width code
    function automatic int unsigned dst_bits(input logic [1:0] code, input int unsigned full);
        case (dst_width_e'(code))
            DW_BYTE: return 8;
            DW_HALF: return 16;
            DW_WORD: return 32;
            default: return full;
        endcase
    endfunction

    // Requested number of results per element for a selector code
    function automatic int unsigned req_count(input logic [1:0] sel);
        return 32'd1 << sel;
    endfunction

endpackage

// File: rtl/vpack_geom.sv
// Module: vpack_geom
// Works out, from the raw configuration inputs, how many results fit in
// one destination element, the per-bit write mask of every write, and
// whether a scalar wide run is too long. Purely combinational; the
// controller samples the outputs only when a run starts.
module vpack_geom #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned VL_MAX = 64,
    parameter int unsigned NIB    = 4,
    parameter int unsigned VLW    = 7
) (
    input  logic            wide_i,
    input  logic            scalar_i,
    input  logic [1:0]      sel_i,
    input  logic [1:0]      ew_i,
    input  logic [VLW-1:0]  vl_i,
    output logic [VLW-1:0]  cap_o,
    output logic [XLEN-1:0] mask_o,
    output logic            vl_err_o
);
    localparam int unsigned SCALAR_NIBS = XLEN / NIB;

    int unsigned req;
    int unsigned dbits;
    int unsigned ncap;
    int unsigned eff;
    int unsigned span;

    // Capacity and write-mask span for the requested layout
    always_comb begin
        req   = vpack_pkg::req_count(sel_i);
        dbits = vpack_pkg::dst_bits(ew_i, XLEN);
        ncap  = dbits / NIB;
        eff   = wide_i ? ((req < ncap) ? req : ncap) : req;
        cap_o = scalar_i ? VLW'(VL_MAX) : VLW'(eff);
        if (scalar_i)
            span = 32'(vl_i) * (wide_i ? NIB : 32'd1);
        else
            span = wide_i ? dbits : XLEN;
        mask_o = (span >= XLEN) ? {XLEN{1'b1}} : ({XLEN{1'b1}} >> (XLEN - span));
    end

    // A scalar wide run longer than the register has nibbles
    assign vl_err_o = scalar_i & wide_i & (32'(vl_i) > SCALAR_NIBS);

endmodule

// File: rtl/vpack_ctrl.sv
// Module: vpack_ctrl
// Run sequencer: captures the configuration on an idle start, counts
// accepted results, tracks the slot inside the current destination
// element and the element offset, decides when an element is flushed,
// and produces the done pulse. Assumes VL between 1 and VL_MAX at start.
module vpack_ctrl #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned VL_MAX = 64,
    parameter int unsigned VLW    = 7,
    parameter int unsigned OFFW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            wide_i,
    input  logic            scalar_i,
    input  logic [VLW-1:0]  vl_i,
    input  logic [VLW-1:0]  cap_i,
    input  logic [XLEN-1:0] mask_i,
    input  logic            verr_i,
    input  logic            res_valid_i,
    output logic            res_ready_o,
    output logic            launch_o,
    output logic            accept_o,
    output logic            flush_o,
    output logic            wide_o,
    output logic            scalar_o,
    output logic [VLW-1:0]  vl_o,
    output logic [VLW-1:0]  slot_o,
    output logic [OFFW-1:0] off_o,
    output logic [XLEN-1:0] mask_o,
    output logic            vl_err_o,
    output logic            done_o
);
    logic            busy;
    logic [VLW-1:0]  idx;
    logic [VLW-1:0]  slot;
    logic [OFFW-1:0] off;
    logic            wide_q;
    logic            scalar_q;
    logic [VLW-1:0]  vl_q;
    logic [VLW-1:0]  cap_q;
    logic [XLEN-1:0] mask_q;
    logic            err_q;
    logic            fin_d;
    logic            done_q;
    logic            last;
    logic            full;
    logic            launch;
    logic            accept;

    assign launch = start_i & ~busy;
    assign accept = busy & res_valid_i;
    assign last   = (idx == (vl_q - VLW'(1)));
    assign full   = (slot == (cap_q - VLW'(1)));

    // Capture the configuration when an idle start arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q   <= 1'b0;
            scalar_q <= 1'b0;
            vl_q     <= VLW'(1);
            cap_q    <= VLW'(1);
            mask_q   <= '0;
            err_q    <= 1'b0;
        end else if (launch) begin
            wide_q   <= wide_i;
            scalar_q <= scalar_i;
            vl_q     <= vl_i;
            cap_q    <= cap_i;
            mask_q   <= mask_i;
            err_q    <= verr_i;
        end
    end

    // Element, slot and offset counting over one run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            slot <= '0;
            off  <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            idx  <= '0;
            slot <= '0;
            off  <= '0;
        end else if (accept) begin
            idx  <= idx + VLW'(1);
            slot <= full ? '0 : slot + VLW'(1);
            if (full | last)
                off <= off + OFFW'(1);
            if (last)
                busy <= 1'b0;
        end
    end

    // Done pulse two edges after the final handshake (one after its write)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_d  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            fin_d  <= accept & last;
            done_q <= fin_d;
        end
    end

    assign res_ready_o = busy;
    assign launch_o    = launch;
    assign accept_o    = accept;
    assign flush_o     = accept & (full | last);
    assign wide_o      = wide_q;
    assign scalar_o    = scalar_q;
    assign vl_o        = vl_q;
    assign slot_o      = slot;
    assign off_o       = off;
    assign mask_o      = mask_q;
    assign vl_err_o    = err_q;
    assign done_o      = done_q;

    // Input assumption: a taken start carries a legal length
    assert_vl_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |-> (vl_i != '0 && 32'(vl_i) <= VL_MAX));

    // Configuration stays frozen while a run continues
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(vl_q) && $stable(cap_q) && $stable(wide_q) && $stable(scalar_q)));

    // Slot never reaches the element capacity
    assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (slot < cap_q));

    // Element index never passes the vector length
    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx < vl_q));

endmodule

// File: rtl/vpack_merge.sv
// Module: vpack_merge
// Accumulates accepted results into the element being built and issues
// the registered write request when the controller flushes it. Narrow
// results use bit 0 only; wide results fill whole nibbles. Positions at
// or beyond XLEN drop out of the shift.
module vpack_merge #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned VLW  = 7,
    parameter int unsigned OFFW = 6,
    parameter int unsigned POSW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch_i,
    input  logic            accept_i,
    input  logic            flush_i,
    input  logic            wide_i,
    input  logic [VLW-1:0]  slot_i,
    input  logic [OFFW-1:0] off_i,
    input  logic [XLEN-1:0] mask_i,
    input  logic [3:0]      res_data_i,
    output logic            wr_en_o,
    output logic [OFFW-1:0] wr_off_o,
    output logic [XLEN-1:0] wr_data_o,
    output logic [XLEN-1:0] wr_mask_o
);
    logic [XLEN-1:0] acc;
    logic [XLEN-1:0] ins;
    logic [XLEN-1:0] acc_next;
    logic [POSW-1:0] pos;
    logic [3:0]      nib;

    // Place the incoming result at its slot position
    always_comb begin
        nib      = wide_i ? res_data_i : {3'b000, res_data_i[0]};
        pos      = wide_i ? {slot_i, 2'b00} : {2'b00, slot_i};
        ins      = {{(XLEN-4){1'b0}}, nib} << pos;
        acc_next = acc | ins;
    end

    // Running element value, cleared after each flush
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (launch_i)
            acc <= '0;
        else if (accept_i)
            acc <= flush_i ? '0 : acc_next;
    end

    // Registered write request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_off_o  <= '0;
            wr_data_o <= '0;
            wr_mask_o <= '0;
        end else begin
            wr_en_o <= accept_i & flush_i;
            if (accept_i & flush_i) begin
                wr_off_o  <= off_i;
                wr_data_o <= acc_next;
                wr_mask_o <= mask_i;
            end
        end
    end

    // Nothing written outside the enabled bits carries a one
    assert_zero_unfilled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ((wr_data_o & ~wr_mask_o) == '0));

    // A write only follows a flushing handshake
    assert_write_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(accept_i && flush_i));

endmodule

// File: rtl/vec_result_packer.sv
// Module: vec_result_packer
// Top level: packs a stream of 1-bit or 4-bit test results into
// consecutive integer register elements, or into one register in scalar
// mode, and issues masked register writes. Assumes the caller holds the
// configuration valid on the start cycle and VL in 1..VL_MAX.
module vec_result_packer #(
    parameter int unsigned XLEN   = vpack_pkg::VP_XLEN,
    parameter int unsigned VL_MAX = vpack_pkg::VP_VL_MAX
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [$clog2(VL_MAX+1)-1:0] vl_i,
    input  logic                      wide_i,
    input  logic                      scalar_i,
    input  logic [1:0]                pack_sel_i,
    input  logic [1:0]                dst_ew_i,
    input  logic                      res_valid_i,
    input  logic [3:0]                res_data_i,
    output logic                      res_ready_o,
    output logic                      wr_en_o,
    output logic [$clog2(VL_MAX)-1:0] wr_off_o,
    output logic [XLEN-1:0]           wr_data_o,
    output logic [XLEN-1:0]           wr_mask_o,
    output logic                      done_o,
    output logic                      vl_err_o
);
    localparam int unsigned VLW  = $clog2(VL_MAX + 1);
    localparam int unsigned OFFW = $clog2(VL_MAX);
    localparam int unsigned POSW = VLW + 2;
    localparam int unsigned NIB  = vpack_pkg::VP_NIB;

    logic [VLW-1:0]  cap_c;
    logic [XLEN-1:0] mask_c;
    logic            verr_c;
    logic            launch;
    logic            accept;
    logic            flush;
    logic            wide_q;
    logic            scalar_q;
    logic [VLW-1:0]  vl_q;
    logic [VLW-1:0]  slot;
    logic [OFFW-1:0] off;
    logic [XLEN-1:0] mask_q;

    vpack_geom #(.XLEN(XLEN), .VL_MAX(VL_MAX), .NIB(NIB), .VLW(VLW)) u_geom (
        .wide_i   (wide_i),
        .scalar_i (scalar_i),
        .sel_i    (pack_sel_i),
        .ew_i     (dst_ew_i),
        .vl_i     (vl_i),
        .cap_o    (cap_c),
        .mask_o   (mask_c),
        .vl_err_o (verr_c)
    );

    vpack_ctrl #(.XLEN(XLEN), .VL_MAX(VL_MAX), .VLW(VLW), .OFFW(OFFW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .wide_i      (wide_i),
        .scalar_i    (scalar_i),
        .vl_i        (vl_i),
        .cap_i       (cap_c),
        .mask_i      (mask_c),
        .verr_i      (verr_c),
        .res_valid_i (res_valid_i),
        .res_ready_o (res_ready_o),
        .launch_o    (launch),
        .accept_o    (accept),
        .flush_o     (flush),
        .wide_o      (wide_q),
        .scalar_o    (scalar_q),
        .vl_o        (vl_q),
        .slot_o      (slot),
        .off_o       (off),
        .mask_o      (mask_q),
        .vl_err_o    (vl_err_o),
        .done_o      (done_o)
    );

    vpack_merge #(.XLEN(XLEN), .VLW(VLW), .OFFW(OFFW), .POSW(POSW)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .accept_i   (accept),
        .flush_i    (flush),
        .wide_i     (wide_q),
        .slot_i     (slot),
        .off_i      (off),
        .mask_i     (mask_q),
        .res_data_i (res_data_i),
        .wr_en_o    (wr_en_o),
        .wr_off_o   (wr_off_o),
        .wr_data_o  (wr_data_o),
        .wr_mask_o  (wr_mask_o)
    );

    // Scalar runs always target the single fixed register
    assert_scalar_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && scalar_q) |-> (wr_off_o == '0));

    // Write offsets stay below the vector length
    assert_offset_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (32'(wr_off_o) < 32'(vl_q)));

    // Done directly follows a write
    assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_en_o));

    // Done lasts a single cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/test_vec_result_packer.sv
// Directed bench for vec_result_packer: one task per scenario, each
// computing its expected writes from the requirements and checking them.
module test_vec_result_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  vl_i = 7'd1;
    logic        wide_i = 1'b0;
    logic        scalar_i = 1'b0;
    logic [1:0]  pack_sel_i = 2'b00;
    logic [1:0]  dst_ew_i = 2'b00;
    logic        res_valid_i = 1'b0;
    logic [3:0]  res_data_i = 4'h0;
    logic        res_ready_o;
    logic        wr_en_o;
    logic [5:0]  wr_off_o;
    logic [63:0] wr_data_o;
    logic [63:0] wr_mask_o;
    logic        done_o;
    logic        vl_err_o;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    // write / done log, written only by the monitor
    logic [5:0]  g_off  [0:1023];
    logic [63:0] g_data [0:1023];
    logic [63:0] g_mask [0:1023];
    int          g_cyc  [0:1023];
    int          wn = 0;
    int          dn = 0;
    int          d_cyc = 0;
    logic        d_ready = 1'b0;

    vec_result_packer i_vec_result_packer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .vl_i        (vl_i),
        .wide_i      (wide_i),
        .scalar_i    (scalar_i),
        .pack_sel_i  (pack_sel_i),
        .dst_ew_i    (dst_ew_i),
        .res_valid_i (res_valid_i),
        .res_data_i  (res_data_i),
        .res_ready_o (res_ready_o),
        .wr_en_o     (wr_en_o),
        .wr_off_o    (wr_off_o),
        .wr_data_o   (wr_data_o),
        .wr_mask_o   (wr_mask_o),
        .done_o      (done_o),
        .vl_err_o    (vl_err_o)
    );

    always #10ns clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Log writes and done pulses between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en_o) begin
                g_off[wn % 1024]  = wr_off_o;
                g_data[wn % 1024] = wr_data_o;
                g_mask[wn % 1024] = wr_mask_o;
                g_cyc[wn % 1024]  = cyc;
                wn = wn + 1;
            end
            if (done_o) begin
                dn = dn + 1;
                d_cyc = cyc;
                d_ready = res_ready_o;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Drive one run and check every write it produces
    task automatic run_case(input bit wide, input bit scalar, input bit [1:0] sel, input bit [1:0] ew,
                            input int vl, input int seed, input bit gaps, input bit disturb,
                            input string req);
        logic [3:0]  r  [0:63];
        logic [63:0] ed [0:63];
        logic [63:0] em;
        int k, w, bw, nexp, wn0, dn0, span, got;
        bw = wide ? 4 : 1;
        w  = (ew == 2'b01) ? 8 : (ew == 2'b10) ? 16 : (ew == 2'b11) ? 32 : 64;
        k  = 1 << sel;
        if (wide && k > w / 4) k = w / 4;
        for (int i = 0; i < 64; i++) ed[i] = '0;
        for (int i = 0; i < vl; i++) begin
            int j, sl, p;
            logic [63:0] rb;
            r[i] = 4'((i * 5 + seed * 3 + (i >> 2)) ^ seed);
            rb = wide ? 64'(r[i]) : 64'(r[i][0]);
            j  = scalar ? 0 : i / k;
            sl = scalar ? i : i % k;
            p  = sl * bw;
            if (p < 64) ed[j] = ed[j] | (rb << p);
        end
        if (scalar) begin
            nexp = 1;
            span = vl * bw;
            em = (span >= 64) ? '1 : ((64'd1 << span) - 64'd1);
        end else begin
            nexp = (vl + k - 1) / k;
            em = (!wide || w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        end
        wn0 = wn;
        dn0 = dn;
        @(negedge clk);
        wide_i = wide; scalar_i = scalar; pack_sel_i = sel; dst_ew_i = ew;
        vl_i = 7'(vl); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(req, "ready during run R10", 64'(res_ready_o), 64'd1);
        for (int i = 0; i < vl; i++) begin
            if (gaps && (i % 3 == 1)) begin
                res_valid_i = 1'b0;
                @(negedge clk);
            end
            if (disturb && i == 2) begin
                start_i = 1'b1; wide_i = ~wide; scalar_i = ~scalar;
                pack_sel_i = ~sel; dst_ew_i = ~ew; vl_i = 7'd3;
            end else begin
                start_i = 1'b0;
            end
            res_valid_i = 1'b1;
            res_data_i = r[i];
            @(negedge clk);
        end
        res_valid_i = 1'b0;
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        got = wn - wn0;
        chk(req, "write count", 64'(got), 64'(nexp));
        for (int j = 0; j < nexp && j < got; j++) begin
            chk(req, $sformatf("offset of write %0d", j), 64'(g_off[(wn0 + j) % 1024]), 64'(j));
            chk(req, $sformatf("data of write %0d", j), g_data[(wn0 + j) % 1024], ed[j]);
            chk(req, $sformatf("mask of write %0d", j), g_mask[(wn0 + j) % 1024], em);
        end
        chk(req, "done pulses R9", 64'(dn - dn0), 64'd1);
        if (got > 0)
            chk(req, "done one cycle after last write R9", 64'(d_cyc), 64'(g_cyc[(wn - 1) % 1024] + 1));
        chk(req, "ready low at done R9", 64'(d_ready), 64'd0);
        chk(req, "length error flag R7", 64'(vl_err_o), 64'(scalar && wide && vl > 16));
    endtask

    task automatic t_reset();
        chk("R11", "wr_en after reset", 64'(wr_en_o), 64'd0);
        chk("R11", "done after reset", 64'(done_o), 64'd0);
        chk("R11", "ready after reset", 64'(res_ready_o), 64'd0);
        chk("R11", "error after reset", 64'(vl_err_o), 64'd0);
    endtask

    task automatic t_narrow_vector();
        for (int s = 0; s < 4; s++) begin
            run_case(1'b0, 1'b0, 2'(s), 2'b00, 11, s + 1, s[0], 1'b0, "R1");
        end
        run_case(1'b0, 1'b0, 2'b11, 2'b01, 16, 9, 1'b0, 1'b0, "R2");
        run_case(1'b0, 1'b0, 2'b00, 2'b00, 1, 4, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_wide_vector();
        run_case(1'b1, 1'b0, 2'b10, 2'b01, 7, 2, 1'b1, 1'b0, "R3");
        run_case(1'b1, 1'b0, 2'b01, 2'b11, 5, 3, 1'b0, 1'b0, "R3");
        run_case(1'b1, 1'b0, 2'b11, 2'b00, 13, 5, 1'b0, 1'b0, "R4");
        run_case(1'b1, 1'b0, 2'b11, 2'b11, 9, 6, 1'b1, 1'b0, "R4");
        run_case(1'b1, 1'b0, 2'b00, 2'b10, 3, 7, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_spill16();
        run_case(1'b1, 1'b0, 2'b11, 2'b10, 8, 11, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_scalar_narrow();
        run_case(1'b0, 1'b1, 2'b01, 2'b10, 40, 12, 1'b1, 1'b0, "R6");
        run_case(1'b0, 1'b1, 2'b00, 2'b00, 64, 13, 1'b0, 1'b0, "R6");
    endtask

    task automatic t_scalar_wide();
        run_case(1'b1, 1'b1, 2'b10, 2'b01, 10, 14, 1'b0, 1'b0, "R7");
        run_case(1'b1, 1'b1, 2'b00, 2'b00, 16, 15, 1'b0, 1'b0, "R7");
        run_case(1'b1, 1'b1, 2'b11, 2'b11, 20, 16, 1'b1, 1'b0, "R7");
    endtask

    task automatic t_latch();
        run_case(1'b1, 1'b0, 2'b10, 2'b11, 10, 17, 1'b0, 1'b1, "R10");
        run_case(1'b0, 1'b0, 2'b01, 2'b00, 7, 18, 1'b1, 1'b1, "R10");
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        #3ms;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_narrow_vector();
        t_wide_vector();
        t_spill16();
        t_scalar_narrow();
        t_scalar_wide();
        t_latch();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule